// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block turns the peripheral clock into the SCL waveform for an I2C master. It also tells the byte engine when to act. A 12-bit divider value is split across two byte-wide registers. A mode bit selects standard or fast timing. From these the block derives the length of the low phase and the high phase, then runs one shared counter through them.

While the byte engine holds its request line high, the block works as follows:

- It drives SCL low for the low phase, then releases it.
- It waits until SCL is actually seen high on the bus, then counts out the high phase.
- It emits a one-cycle data-change strobe in the middle of each low phase.
- It emits a one-cycle sample strobe in the middle of each counted high phase.

A slave that holds SCL low after release stretches the high phase. Every new request starts from a fresh, full low phase. When the request is dropped, SCL is released on the next cycle.

Top module: `scl_div_gen`

## Requirements
- R1: After reset both divider registers read 0x00, SCL is released (high) and neither strobe is active.
- R2: The control register reads back the byte last written. Its bit 7 selects fast mode (1) or standard mode (0). Its bits 6:0 are divider bits 6:0.
- R3: The extension register holds divider bits 11:7 in its bits 4:0. Its bits 7:5 always read 0.
- R4: In standard mode with divider D, one SCL period is 2D+5 clock cycles: a high phase of D+2 cycles and a low phase of D+3 cycles.
- R5: In fast mode with divider D, one SCL period is 3D+6 clock cycles: a high phase of D+2 cycles and a low phase of 2D+4 cycles.
- R6: Divider values 0 and 1 produce exactly the timing of divider 2.
- R7: The high-phase count advances only in cycles where SCL is sampled high. Each cycle that an external device holds SCL low after release lengthens the high phase by one cycle.
- R8: One cycle after the request input is seen low, SCL is released and both strobes are inactive. This holds even in the middle of a phase.
- R9: The first clock edge that sees the request high after idle starts a full-length low phase.
- R10: The data-change strobe pulses exactly once per low phase, at cycle index floor(low/2) counted from 0.
- R11: The sample strobe pulses exactly once per high phase, at counted-high cycle index floor(high/2), and only while SCL is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Write strobe for the control register |
| extWr | input | 1 | Write strobe for the extension register |
| wrData | input | 8 | Write data for either register |
| ctrlRd | output | 8 | Control register read value |
| extRd | output | 8 | Extension register read value |
| runReq | input | 1 | Bus activity request from the byte engine |
| sclIn | input | 1 | Sampled SCL level on the bus |
| sclOut | output | 1 | SCL level driven by the master (0 = pull low) |
| sampleStb | output | 1 | High-phase midpoint strobe |
| changeStb | output | 1 | Low-phase data-change strobe |

## Verification
The bench builds the block with its default parameters: a 12-bit divider and byte-wide registers.

It sweeps divider values 0 through 9 in both modes, which covers the clamped values and the smallest legal phase lengths. It adds values that span both registers, including the full-scale 4095. Each value is measured against the closed-form phase lengths and strobe positions.

SCL is looped back through a bench-controlled pull-down. This makes a stretched high phase reachable. It also makes reachable a request dropped in mid-phase and then restarted.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  // Fixed overheads of the period formulas
  localparam int STD_OVH  = 5;
  localparam int FAST_OVH = 6;
  localparam int HIGH_OVH = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cnt_cmd_s;

  // datapath -> control
  typedef struct packed {
    logic lowLast;
    logic highLast;
    logic lowMid;
    logic highMid;
  } cnt_stat_s;

endpackage

// File: rtl/scl_div_dp.sv
module scl_div_dp
  import scl_div_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int REG_W   = 8,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             extWr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlRd,
  output logic [REG_W-1:0] extRd,
  input  cnt_cmd_s         cmd,
  output cnt_stat_s        stat
);

  localparam int LO_W  = REG_W - 1;      // divider bits in the control register
  localparam int HI_W  = DIV_W - LO_W;   // divider bits in the extension register
  localparam int CNT_W = DIV_W + 2;      // holds 3*Dmax + overhead

  logic [REG_W-1:0] ctrlReg;
  logic [HI_W-1:0]  extReg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      extReg  <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= wrData;
      if (extWr)  extReg  <= wrData[HI_W-1:0];
    end
  end

  assign ctrlRd = ctrlReg;
  assign extRd  = {{(REG_W-HI_W){1'b0}}, extReg};

  logic             fastMode;
  logic [DIV_W-1:0] rawDiv;
  logic [DIV_W-1:0] effDiv;
  logic [CNT_W-1:0] divW;
  logic [CNT_W-1:0] periodLen;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] lowLen;

  always_comb begin
    fastMode = ctrlReg[REG_W-1];
    rawDiv   = {extReg, ctrlReg[LO_W-1:0]};
    effDiv   = (rawDiv < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : rawDiv;
    divW     = CNT_W'(effDiv);
    periodLen = fastMode ? (divW + divW + divW + CNT_W'(FAST_OVH))
                         : (divW + divW + CNT_W'(STD_OVH));
    highLen  = divW + CNT_W'(HIGH_OVH);
    lowLen   = periodLen - highLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (cmd.cntClr) cnt <= '0;
    else if (cmd.cntInc) cnt <= cnt + 1'b1;
  end

  // >= keeps a phase finite if the divider is rewritten mid-phase
  always_comb begin
    stat.lowLast  = (cnt >= lowLen - 1'b1);
    stat.highLast = (cnt >= highLen - 1'b1);
    stat.lowMid   = (cnt == (lowLen >> 1));
    stat.highMid  = (cnt == (highLen >> 1));
  end

endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runReq,
  input  logic      sclIn,
  input  cnt_stat_s stat,
  output cnt_cmd_s  cmd,
  output logic      sclOut,
  output logic      sampleStb,
  output logic      changeStb
);

  phase_e phase, phaseNxt;

  always_comb begin
    phaseNxt   = phase;
    cmd.cntClr = 1'b0;
    cmd.cntInc = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        cmd.cntClr = 1'b1;
        if (runReq) phaseNxt = PH_LOW;
      end
      PH_LOW: begin
        if (!runReq) begin
          phaseNxt   = PH_IDLE;
          cmd.cntClr = 1'b1;
        end else if (stat.lowLast) begin
          phaseNxt   = PH_HIGH;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!runReq) begin
          phaseNxt   = PH_IDLE;
          cmd.cntClr = 1'b1;
        end else if (sclIn) begin
          if (stat.highLast) begin
            phaseNxt   = PH_LOW;
            cmd.cntClr = 1'b1;
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
      end
      default: begin
        phaseNxt   = PH_IDLE;
        cmd.cntClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign sclOut    = (phase != PH_LOW);
  assign changeStb = (phase == PH_LOW)  && stat.lowMid;
  assign sampleStb = (phase == PH_HIGH) && sclIn && stat.highMid;

  // R8: dropping the request releases the bus on the next cycle
  a_r8_release_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    !runReq |=> (sclOut && !sampleStb && !changeStb));

  // R9: a request from idle starts with a low phase
  a_r9_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && runReq) |=> (phase == PH_LOW));

  // R7: a stretched SCL holds the high phase
  a_r7_hold_while_stretched: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && runReq && !sclIn) |=> (phase == PH_HIGH));

  // R10: the change strobe is a single-cycle pulse
  a_r10_change_single: assert property (@(posedge clk) disable iff (!rstN)
    changeStb |=> !changeStb);

  // R11: the sample strobe is a single-cycle pulse
  a_r11_sample_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

endmodule

// File: rtl/scl_div_gen.sv
module scl_div_gen
  import scl_div_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int REG_W   = 8,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             extWr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlRd,
  output logic [REG_W-1:0] extRd,
  input  logic             runReq,
  input  logic             sclIn,
  output logic             sclOut,
  output logic             sampleStb,
  output logic             changeStb
);

  cnt_cmd_s  cmd;
  cnt_stat_s stat;

  scl_div_dp #(
    .DIV_W  (DIV_W),
    .REG_W  (REG_W),
    .MIN_DIV(MIN_DIV)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlWr (ctrlWr),
    .extWr  (extWr),
    .wrData (wrData),
    .ctrlRd (ctrlRd),
    .extRd  (extRd),
    .cmd    (cmd),
    .stat   (stat)
  );

  scl_div_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .runReq    (runReq),
    .sclIn     (sclIn),
    .stat      (stat),
    .cmd       (cmd),
    .sclOut    (sclOut),
    .sampleStb (sampleStb),
    .changeStb (changeStb)
  );

endmodule

// File: tb/sim_scl_div_gen.sv
module sim_scl_div_gen;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic       extWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] ctrlRd;
  logic [7:0] extRd;
  logic       runReq = 1'b0;
  logic       stretch = 1'b0;
  logic       sclIn;
  logic       sclOut;
  logic       sampleStb;
  logic       changeStb;

  int checks = 0;
  int errors = 0;

  assign sclIn = sclOut & ~stretch;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_div_gen u0 (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .extWr     (extWr),
    .wrData    (wrData),
    .ctrlRd    (ctrlRd),
    .extRd     (extRd),
    .runReq    (runReq),
    .sclIn     (sclIn),
    .sclOut    (sclOut),
    .sampleStb (sampleStb),
    .changeStb (changeStb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit ext, input logic [7:0] d);
    @(negedge clk);
    ctrlWr = !ext;
    extWr  = ext;
    wrData = d;
    @(negedge clk);
    ctrlWr = 1'b0;
    extWr  = 1'b0;
  endtask

  task automatic setDiv(input bit fast, input int d);
    logic [11:0] dv;
    dv = 12'(d);
    wr(1'b0, {fast, dv[6:0]});
    wr(1'b1, {3'b000, dv[11:7]});
  endtask

  // One full low + high phase from a fresh request
  task automatic measure(input bit fast, input int d, input string req);
    int e, hiExp, loExp, loCnt, hiCnt, chgN, chgIdx, smpN, smpIdx, guard;
    e      = (d < 2) ? 2 : d;
    hiExp  = e + 2;
    loExp  = fast ? (2*e + 4) : (e + 3);
    setDiv(fast, d);
    @(negedge clk);
    runReq = 1'b1;
    @(negedge clk);
    loCnt = 0; chgN = 0; chgIdx = -1; guard = 0;
    while (sclOut == 1'b0 && guard < GUARD) begin
      if (changeStb) begin chgN++; chgIdx = loCnt; end
      if (sampleStb) chgN += 10;
      loCnt++; guard++;
      @(negedge clk);
    end
    hiCnt = 0; smpN = 0; smpIdx = -1; guard = 0;
    while (sclOut == 1'b1 && guard < GUARD) begin
      if (sampleStb) begin smpN++; smpIdx = hiCnt; end
      if (changeStb) smpN += 10;
      hiCnt++; guard++;
      @(negedge clk);
    end
    runReq = 1'b0;
    chk(loCnt == loExp, req, loCnt, loExp);
    chk(hiCnt == hiExp, req, hiCnt, hiExp);
    chk(loCnt + hiCnt == (fast ? 3*e + 6 : 2*e + 5), req, loCnt + hiCnt,
        fast ? 3*e + 6 : 2*e + 5);
    chk(chgN == 1 && chgIdx == loExp/2, "R10", chgIdx, loExp/2);
    chk(smpN == 1 && smpIdx == hiExp/2, "R11", smpIdx, hiExp/2);
    @(negedge clk);
    chk(sclOut && !sampleStb && !changeStb, "R8", int'(sclOut), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int loCnt, hiCnt, smpIdx, smpN, guard;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ctrlRd == 8'h00, "R1", int'(ctrlRd), 0);
    chk(extRd == 8'h00, "R1", int'(extRd), 0);
    chk(sclOut && !sampleStb && !changeStb, "R1", int'(sclOut), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(sclOut && !sampleStb && !changeStb, "R1", int'(sclOut), 1);

    // R2 / R3: register read-back
    wr(1'b0, 8'hA5);
    chk(ctrlRd == 8'hA5, "R2", int'(ctrlRd), 8'hA5);
    wr(1'b1, 8'hFF);
    chk(extRd == 8'h1F, "R3", int'(extRd), 8'h1F);
    wr(1'b1, 8'hE0);
    chk(extRd == 8'h00, "R3", int'(extRd), 0);

    // R4 / R5 / R6: divider sweep in both modes
    for (int f = 0; f < 2; f++) begin
      for (int d = 0; d < 10; d++) begin
        measure(f[0], d, (d < 2) ? "R6" : (f != 0 ? "R5" : "R4"));
      end
    end
    measure(1'b0, 165, "R4");
    measure(1'b1, 165, "R5");
    measure(1'b0, 4095, "R4");
    measure(1'b1, 4095, "R5");

    // R7: stretch the high phase, std D=3 (high 5, low 6)
    setDiv(1'b0, 3);
    @(negedge clk);
    stretch = 1'b1;
    runReq  = 1'b1;
    @(negedge clk);
    loCnt = 0; guard = 0;
    while (sclOut == 1'b0 && guard < GUARD) begin
      loCnt++; guard++;
      @(negedge clk);
    end
    chk(loCnt == 6, "R7", loCnt, 6);
    hiCnt = 0; smpN = 0; smpIdx = -1;
    for (int i = 0; i < 4; i++) begin
      chk(!sampleStb && sclOut, "R7", int'(sampleStb), 0);
      hiCnt++;
      if (i < 3) @(negedge clk);
    end
    stretch = 1'b0;
    @(negedge clk);
    guard = 0;
    while (sclOut == 1'b1 && guard < GUARD) begin
      if (sampleStb) begin smpN++; smpIdx = hiCnt; end
      hiCnt++; guard++;
      @(negedge clk);
    end
    runReq = 1'b0;
    chk(hiCnt == 8, "R7", hiCnt, 8);
    chk(smpN == 1 && smpIdx == 5, "R11", smpIdx, 5);
    @(negedge clk);

    // R8 / R9: drop mid low phase, restart with full low phase (std D=5, low 8)
    setDiv(1'b0, 5);
    @(negedge clk);
    runReq = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclOut == 1'b0, "R9", int'(sclOut), 0);
    runReq = 1'b0;
    @(negedge clk);
    chk(sclOut && !changeStb && !sampleStb, "R8", int'(sclOut), 1);
    runReq = 1'b1;
    @(negedge clk);
    loCnt = 0; guard = 0;
    while (sclOut == 1'b0 && guard < GUARD) begin
      loCnt++; guard++;
      @(negedge clk);
    end
    chk(loCnt == 8, "R9", loCnt, 8);
    runReq = 1'b0;
    @(negedge clk);
    chk(sclOut == 1'b1, "R8", int'(sclOut), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule